// File: doc/BRIEF.md
# Dual-rail completion detector

This block receives an N-bit word in redundant two-wire form: every logical bit travels on a pair of wires, rail P and rail Q. When both wires of a pair agree, the pair carries a settled value: both low means 0 and both high means 1. When the two wires disagree, the bit is still moving or is resting between words. The detector turns each pair into one registered data bit. While its pair is mixed, that bit keeps its last decoded value. The block also raises a single word-level done flag once every pair has settled.

Done comes from a tree of 2-input hysteresis join elements. Each element's output goes high when both of its inputs are high, goes low when both are low, and otherwise keeps its state. The leaves of the tree are the per-pair agreement signals. As a result, done rises only after the whole word has arrived. It falls only after the whole word has gone back to the mixed resting state, which gives a four-phase style of completion.

A separate converter goes the other way. It takes single-rail data with a request flag and builds the two-wire form: a valid code when the request is high, and the resting code when it is low. All outputs are registered on the system clock. The pair inputs are assumed to be synchronous to that clock.

Top module: `dr_done_detect`

## Requirements
- R1: While `rst` is high, on each clock edge `word_out` and `word_done` clear to 0, `enc_p` clears to all zeros and `enc_q` sets to all ones.
- R2: If pair i carries P=0,Q=0 at a clock edge, bit i of `word_out` is 0 after that edge. If it carries P=1,Q=1, the bit is 1 after that edge.
- R3: If pair i carries a mixed code (P=0,Q=1 or P=1,Q=0) at a clock edge, bit i of `word_out` keeps its value across that edge. This holds even when the pair flips from one mixed code to the other.
- R4: If every pair carries a matching code at a clock edge, `word_done` is 1 after that edge.
- R5: When pairs move one way only within a phase (valid towards mixed, or mixed towards valid), `word_done` keeps its value across any edge where some pairs match and others do not.
- R6: If every pair carries a mixed code at a clock edge, `word_done` is 0 after that edge.
- R7: After a clock edge with `src_req` high, `enc_p` and `enc_q` both equal `src_data`. After a clock edge with `src_req` low, the converter drives the resting code: `enc_p` all zeros and `enc_q` all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_p | input | N | P wire of each incoming pair |
| rail_q | input | N | Q wire of each incoming pair |
| word_out | output | N | Decoded single-rail word, held per bit on mixed codes |
| word_done | output | 1 | Word-level completion flag from the join tree |
| src_data | input | N | Single-rail data to be converted |
| src_req | input | 1 | Request: high sends a valid code, low sends the resting code |
| enc_p | output | N | P wire of each converted pair |
| enc_q | output | N | Q wire of each converted pair |

## Verification
The most delicate coincidence happens when the last pair of a word settles. On that edge its decoded bit updates and `word_done` rises together, while all earlier bits must stay unchanged. The bench randomises which pair arrives last, and in the directed part it makes all pairs arrive on the same edge. It then compares both outputs in the same sample against its own model. The converter is fed fresh random data and requests every cycle, so its update always shares an edge with the detector's decode, hold and completion decisions, and both are judged in that same cycle.

// File: rtl/dr_pkg.sv
`timescale 1ns/1ps
package dr_pkg;
  // Resting code produced by the converter: P low, Q high.
  localparam logic REST_P = 1'b0;
  localparam logic REST_Q = 1'b1;

  // Hysteresis join: rises when both inputs are high, falls when both low.
  function automatic logic c_join(input logic x, input logic y, input logic prev);
    return (x & y) | (prev & (x | y));
  endfunction
endpackage

// File: rtl/dr_rail_decode.sv
`timescale 1ns/1ps
module dr_rail_decode #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rail_p,
  input  logic [N-1:0] rail_q,
  output logic [N-1:0] agree,
  output logic [N-1:0] word_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign agree[i] = ~(rail_p[i] ^ rail_q[i]);
    always_ff @(posedge clk) begin
      if (rst)
        word_q[i] <= 1'b0;
      else if (agree[i])
        word_q[i] <= rail_p[i];
    end
  end
endmodule

// File: rtl/dr_join_tree.sv
`timescale 1ns/1ps
module dr_join_tree #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] leaf,
  output logic         done
);
  localparam int LVL    = (N < 2) ? 1 : $clog2(N);
  localparam int LEAVES = 1 << LVL;

  // Heap layout: node k has children 2k and 2k+1; leaves start at LEAVES.
  logic nxt [1:2*LEAVES-1];
  logic st  [1:LEAVES-1];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < N) begin : g_real
      assign nxt[LEAVES+j] = leaf[j];
    end else begin : g_pad
      assign nxt[LEAVES+j] = leaf[0];
    end
  end

  for (genvar k = 1; k < LEAVES; k++) begin : g_node
    assign nxt[k] = dr_pkg::c_join(nxt[2*k], nxt[2*k+1], st[k]);
    always_ff @(posedge clk) begin
      if (rst)
        st[k] <= 1'b0;
      else
        st[k] <= nxt[k];
    end
  end

  assign done = st[1];
endmodule

// File: rtl/dr_rail_encode.sv
`timescale 1ns/1ps
module dr_rail_encode #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_data,
  input  logic         src_req,
  output logic [N-1:0] enc_p,
  output logic [N-1:0] enc_q
);
  always_ff @(posedge clk) begin
    if (rst || !src_req) begin
      enc_p <= {N{dr_pkg::REST_P}};
      enc_q <= {N{dr_pkg::REST_Q}};
    end else begin
      enc_p <= src_data;
      enc_q <= src_data;
    end
  end
endmodule

// File: rtl/dr_done_detect.sv
`timescale 1ns/1ps
module dr_done_detect #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rail_p,
  input  logic [N-1:0] rail_q,
  output logic [N-1:0] word_out,
  output logic         word_done,
  input  logic [N-1:0] src_data,
  input  logic         src_req,
  output logic [N-1:0] enc_p,
  output logic [N-1:0] enc_q
);
  logic [N-1:0] agree;

  dr_rail_decode #(.N(N)) u_dec (
    .clk(clk), .rst(rst), .rail_p(rail_p), .rail_q(rail_q),
    .agree(agree), .word_q(word_out)
  );

  dr_join_tree #(.N(N)) u_tree (
    .clk(clk), .rst(rst), .leaf(agree), .done(word_done)
  );

  dr_rail_encode #(.N(N)) u_enc (
    .clk(clk), .rst(rst), .src_data(src_data), .src_req(src_req),
    .enc_p(enc_p), .enc_q(enc_q)
  );
endmodule

// File: rtl/dr_done_detect_chk.sv
`timescale 1ns/1ps
module dr_done_detect_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] rail_p,
  input logic [N-1:0] rail_q,
  input logic [N-1:0] word_out,
  input logic         word_done,
  input logic [N-1:0] src_data,
  input logic         src_req,
  input logic [N-1:0] enc_p,
  input logic [N-1:0] enc_q
);
  logic [N-1:0] match;
  assign match = rail_p ~^ rail_q;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (word_out == '0 && !word_done && enc_p == '0 && enc_q == '1));

  assert_valid_decode_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((word_out ^ $past(rail_p)) & $past(match)) == '0));

  assert_mixed_hold_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((word_out ^ $past(word_out)) & ~$past(match)) == '0));

  assert_all_valid_done_R4: assert property (@(posedge clk) disable iff (rst)
    (&match) |=> word_done);

  assert_all_mixed_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (match == '0) |=> !word_done);

  assert_convert_valid_R7: assert property (@(posedge clk) disable iff (rst)
    src_req |=> (enc_p == $past(src_data) && enc_q == $past(src_data)));

  assert_convert_rest_R7: assert property (@(posedge clk) disable iff (rst)
    !src_req |=> (enc_p == '0 && enc_q == '1));
endmodule

bind dr_done_detect dr_done_detect_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .rail_p(rail_p), .rail_q(rail_q),
  .word_out(word_out), .word_done(word_done),
  .src_data(src_data), .src_req(src_req), .enc_p(enc_p), .enc_q(enc_q)
);

// File: tb/dr_done_detect_test.sv
`timescale 1ns/1ps
module dr_done_detect_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] rail_p, rail_q, src_data, word_out, enc_p, enc_q;
  logic         src_req, word_done;

  logic [N-1:0] exp_word, exp_p, exp_q;
  logic         exp_done;
  logic [N-1:0] cur_p, cur_q;
  int           checks = 0;
  int           fails  = 0;

  always #10 clk = ~clk;

  dr_done_detect #(.N(N)) uut (
    .clk(clk), .rst(rst), .rail_p(rail_p), .rail_q(rail_q),
    .word_out(word_out), .word_done(word_done),
    .src_data(src_data), .src_req(src_req), .enc_p(enc_p), .enc_q(enc_q)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle of inputs, update the model, sample after the edge.
  task automatic step(input logic r, input logic [N-1:0] p, input logic [N-1:0] q,
                      input logic [N-1:0] d, input logic req);
    logic [N-1:0] agr;
    string dtag;
    rst = r; rail_p = p; rail_q = q; src_data = d; src_req = req;
    agr = p ~^ q;
    if (r) begin
      exp_word = '0; exp_done = 1'b0; exp_p = '0; exp_q = '1;
    end else begin
      exp_word = (exp_word & ~agr) | (p & agr);
      if (&agr) exp_done = 1'b1;
      else if (agr == '0) exp_done = 1'b0;
      exp_p = req ? d : '0;
      exp_q = req ? d : '1;
    end
    @(posedge clk);
    @(negedge clk);
    if (r) begin
      chk("R1 word", word_out, exp_word);
      chk("R1 done", {{(N-1){1'b0}}, word_done}, {{(N-1){1'b0}}, exp_done});
      chk("R1 encp", enc_p, exp_p);
      chk("R1 encq", enc_q, exp_q);
    end else begin
      chk("R2", word_out & agr, exp_word & agr);
      if (agr != '1) chk("R3", word_out & ~agr, exp_word & ~agr);
      dtag = (&agr) ? "R4" : ((agr == '0) ? "R6" : "R5");
      chk(dtag, {{(N-1){1'b0}}, word_done}, {{(N-1){1'b0}}, exp_done});
      chk("R7 p", enc_p, exp_p);
      chk("R7 q", enc_q, exp_q);
    end
  endtask

  task automatic rnd_cycle();
    step(1'b0, cur_p, cur_q, N'($urandom), 1'($urandom));
  endtask

  // Valid pairs drift to mixed codes one by one; mixed ones may flip.
  task automatic to_rest();
    while ((cur_p ~^ cur_q) != '0) begin
      for (int i = 0; i < N; i++) begin
        if (cur_p[i] == cur_q[i]) begin
          if ($urandom % 3 == 0) begin
            cur_p[i] = 1'($urandom);
            cur_q[i] = ~cur_p[i];
          end
        end else if ($urandom % 4 == 0) begin
          cur_p[i] = ~cur_p[i];
          cur_q[i] = ~cur_q[i];
        end
      end
      rnd_cycle();
    end
  endtask

  // Mixed pairs settle to the new word one by one.
  task automatic to_word(input logic [N-1:0] w);
    while ((cur_p ~^ cur_q) != '1) begin
      for (int i = 0; i < N; i++) begin
        if (cur_p[i] != cur_q[i]) begin
          if ($urandom % 3 == 0) begin
            cur_p[i] = w[i];
            cur_q[i] = w[i];
          end else if ($urandom % 4 == 0) begin
            cur_p[i] = ~cur_p[i];
            cur_q[i] = ~cur_q[i];
          end
        end
      end
      rnd_cycle();
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h0D0E_5EED));
    exp_word = '0; exp_done = 1'b0; exp_p = '0; exp_q = '1;
    cur_p = '0; cur_q = '1;
    // R1: reset state, resting inputs
    step(1'b1, cur_p, cur_q, 8'hFF, 1'b1);
    step(1'b1, cur_p, cur_q, 8'h00, 1'b0);

    // R4/R2: every pair settles on the same edge
    cur_p = 8'hA5; cur_q = 8'hA5;
    step(1'b0, cur_p, cur_q, 8'h5A, 1'b1);
    // R2: valid to valid directly, done stays high
    cur_p = 8'h3C; cur_q = 8'h3C;
    step(1'b0, cur_p, cur_q, 8'hC3, 1'b0);
    // R5/R3: a single pair goes mixed, done and that bit hold
    cur_p[2] = ~cur_q[2];
    step(1'b0, cur_p, cur_q, 8'h11, 1'b1);
    // R3: mixed pair flips to the other mixed code
    cur_p[2] = ~cur_p[2]; cur_q[2] = ~cur_q[2];
    step(1'b0, cur_p, cur_q, 8'h22, 1'b1);
    // R6: every remaining pair goes mixed
    cur_p = 8'h0F; cur_q = 8'hF0;
    step(1'b0, cur_p, cur_q, 8'h33, 1'b0);
    // R5: half the pairs settle, done stays low
    cur_p = 8'h0F; cur_q = 8'hFF;
    step(1'b0, cur_p, cur_q, 8'h44, 1'b1);
    // R4: the last pairs settle
    cur_p = 8'hFF;
    step(1'b0, cur_p, cur_q, 8'h55, 1'b1);

    // Random four-phase traffic
    for (int w = 0; w < 60; w++) begin
      to_rest();
      rnd_cycle();
      to_word(N'($urandom));
      rnd_cycle();
    end

    // R1: reset in the middle of a valid word, then release
    step(1'b1, cur_p, cur_q, 8'h77, 1'b1);
    step(1'b0, cur_p, cur_q, 8'h88, 1'b1);
    to_rest();
    to_word(8'h00);
    to_rest();
    to_word(8'hFF);

    summary();
    $finish;
  end
endmodule